// File: doc/BRIEF.md
# Shared-Operator Quadratic Evaluator

This block evaluates the second-order polynomial y = A·x² + B·x + C on signed two's-complement operands of width `W`. It has exactly one multiplier and one adder. A short step sequencer reuses the multiplier for the squaring of x, for B·x and for A·x², and reuses the adder for adding C and for the final sum. Operand selectors in front of the two shared units route the right sources in each step. This trades throughput for area: one result every five clock cycles instead of one per cycle from a fully spatial datapath.

A one-cycle `start` pulse while the block is idle captures `x` and begins an evaluation. The coefficients are read directly from their input ports at the step that uses them, so the surrounding logic holds them steady until `done` appears. `done` pulses for one cycle together with the new value on `y`. The result is the exact polynomial wrapped to `W` bits.

Top module: `quad_eval`

## Requirements
- R1: After reset, `y` reads 0 and `done` reads 0.
- R2: `y` equals (A·x² + B·x + C) modulo 2^W, where x is the value on `x_in` at the clock edge that accepted `start`. All values are interpreted as signed two's-complement W-bit numbers, and every intermediate product and sum wraps to W bits.
- R3: Counting the edge that accepted `start` as edge 1, `done` is high during the clock cycle that follows edge 5, and `y` carries the new result in that same cycle.
- R4: While an evaluation is in progress, `start` pulses and changes on `x_in` have no effect: the result still uses the captured x, and only one `done` pulse appears.
- R5: `y` changes only in a cycle in which `done` is high. Between results it holds its value.
- R6: `done` is never high for two consecutive cycles.
- R7: A `start` pulse that is sampled in the cycle in which `done` is high is accepted. Evaluations can therefore run back to back, one every five cycles.
- R8: While the block is idle and `start` is low, `done` stays low and `y` keeps its value, whatever `x_in` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin an evaluation (honoured only while idle) |
| x_in | input | W | Signed sample, captured when start is accepted |
| coef_a | input | W | Signed coefficient of x² |
| coef_b | input | W | Signed coefficient of x |
| coef_c | input | W | Signed constant term |
| y | output | W | Signed result, wrapped to W bits |
| done | output | 1 | One-cycle pulse marking a new result on y |

## Verification
The assertions assume that `start` and `x_in` may toggle freely, but that the coefficient inputs stay constant from the accepting edge until `done`, because the datapath reads them at steps two to four. The bench changes the coefficients only at the start of a new evaluation. It disturbs `x_in` and `start` inside busy windows, so the assumption holds while the ignored-input paths are still exercised. The bench sweeps every x, A and B at a width of four bits, with C derived from the other three, and computes each expected result as wrapped integer arithmetic.

// File: rtl/quad_pkg.sv
package quad_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SQR   = 3'd1,
    ST_BX    = 3'd2,
    ST_SUMC  = 3'd3,
    ST_FINAL = 3'd4
  } step_e;

  typedef enum logic {
    MA_X  = 1'b0,
    MA_XX = 1'b1
  } ma_sel_e;

  typedef enum logic [1:0] {
    MB_X   = 2'b00,
    MB_B   = 2'b01,
    MB_A   = 2'b10,
    MB_RSV = 2'b11
  } mb_sel_e;

  typedef enum logic {
    AD_C   = 1'b0,
    AD_BXC = 1'b1
  } ad_sel_e;

  typedef struct packed {
    ma_sel_e ma;
    mb_sel_e mb;
    ad_sel_e ad;
    logic    ld_x;
    logic    ld_xx;
    logic    ld_prod;
    logic    ld_bxc;
    logic    ld_y;
  } ctrl_t;

endpackage

// File: rtl/quad_rst_sync.sv
module quad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/quad_dreg.sv
module quad_dreg #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] d,
  output logic signed [W-1:0] q
);

  logic signed [W-1:0] q_nx;

  always_comb begin
    q_nx = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end

endmodule

// File: rtl/quad_sequencer.sv
module quad_sequencer
  import quad_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output step_e step_q,
  output ctrl_t ctrl,
  output logic  done_q
);

  step_e step_nx;
  logic  done_nx;

  // next step
  always_comb begin
    step_nx = step_q;
    unique case (step_q)
      ST_IDLE:  if (start) step_nx = ST_SQR;
      ST_SQR:   step_nx = ST_BX;
      ST_BX:    step_nx = ST_SUMC;
      ST_SUMC:  step_nx = ST_FINAL;
      ST_FINAL: step_nx = ST_IDLE;
      default:  step_nx = ST_IDLE;
    endcase
  end

  // control word for the shared datapath
  always_comb begin
    ctrl = '{ma: MA_X, mb: MB_X, ad: AD_C,
             ld_x: 1'b0, ld_xx: 1'b0, ld_prod: 1'b0, ld_bxc: 1'b0, ld_y: 1'b0};
    unique case (step_q)
      ST_IDLE: begin
        ctrl.ld_x = start;
      end
      ST_SQR: begin
        ctrl.ma      = MA_X;
        ctrl.mb      = MB_X;
        ctrl.ld_xx   = 1'b1;
        ctrl.ld_prod = 1'b1;
      end
      ST_BX: begin
        ctrl.ma      = MA_X;
        ctrl.mb      = MB_B;
        ctrl.ld_prod = 1'b1;
      end
      ST_SUMC: begin
        ctrl.ad      = AD_C;
        ctrl.ld_bxc  = 1'b1;
        ctrl.ma      = MA_XX;
        ctrl.mb      = MB_A;
        ctrl.ld_prod = 1'b1;
      end
      ST_FINAL: begin
        ctrl.ad   = AD_BXC;
        ctrl.ld_y = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    done_nx = ctrl.ld_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_nx;
      done_q <= done_nx;
    end
  end

endmodule

// File: rtl/quad_operand_mux.sv
module quad_operand_mux
  import quad_pkg::*;
#(
  parameter int W = 16
) (
  input  ctrl_t               ctrl,
  input  logic signed [W-1:0] x_q,
  input  logic signed [W-1:0] xx_q,
  input  logic signed [W-1:0] bxc_q,
  input  logic signed [W-1:0] coef_a,
  input  logic signed [W-1:0] coef_b,
  input  logic signed [W-1:0] coef_c,
  output logic signed [W-1:0] mul_lhs,
  output logic signed [W-1:0] mul_rhs,
  output logic signed [W-1:0] add_rhs
);

  // two-way selector for the first multiplier operand
  always_comb begin
    mul_lhs = (ctrl.ma == MA_XX) ? xx_q : x_q;
  end

  // three-way selector for the second multiplier operand
  always_comb begin
    unique case (ctrl.mb)
      MB_B:    mul_rhs = coef_b;
      MB_A:    mul_rhs = coef_a;
      default: mul_rhs = x_q;
    endcase
  end

  // two-way selector for the adder side not fed by the product
  always_comb begin
    add_rhs = (ctrl.ad == AD_BXC) ? bxc_q : coef_c;
  end

endmodule

// File: rtl/quad_shared_alu.sv
module quad_shared_alu #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] mul_lhs,
  input  logic signed [W-1:0] mul_rhs,
  input  logic signed [W-1:0] prod_q,
  input  logic signed [W-1:0] add_rhs,
  output logic signed [W-1:0] product,
  output logic signed [W-1:0] sum
);

  // single multiplier, wrapped to W bits
  always_comb begin
    product = mul_lhs * mul_rhs;
  end

  // single adder: one side always the registered product
  always_comb begin
    sum = prod_q + add_rhs;
  end

endmodule

// File: rtl/quad_eval.sv
module quad_eval
  import quad_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] coef_a,
  input  logic signed [W-1:0] coef_b,
  input  logic signed [W-1:0] coef_c,
  output logic signed [W-1:0] y,
  output logic                done
);

  logic                rst_int_n;
  step_e               step_q;
  ctrl_t               ctrl;
  logic signed [W-1:0] x_q;
  logic signed [W-1:0] xx_q;
  logic signed [W-1:0] prod_q;
  logic signed [W-1:0] bxc_q;
  logic signed [W-1:0] mul_lhs;
  logic signed [W-1:0] mul_rhs;
  logic signed [W-1:0] add_rhs;
  logic signed [W-1:0] product;
  logic signed [W-1:0] sum;

  quad_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  quad_sequencer u_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start),
    .step_q (step_q),
    .ctrl   (ctrl),
    .done_q (done)
  );

  quad_operand_mux #(.W(W)) u_mux (
    .ctrl    (ctrl),
    .x_q     (x_q),
    .xx_q    (xx_q),
    .bxc_q   (bxc_q),
    .coef_a  (coef_a),
    .coef_b  (coef_b),
    .coef_c  (coef_c),
    .mul_lhs (mul_lhs),
    .mul_rhs (mul_rhs),
    .add_rhs (add_rhs)
  );

  quad_shared_alu #(.W(W)) u_alu (
    .mul_lhs (mul_lhs),
    .mul_rhs (mul_rhs),
    .prod_q  (prod_q),
    .add_rhs (add_rhs),
    .product (product),
    .sum     (sum)
  );

  quad_dreg #(.W(W)) u_x_reg (
    .clk (clk), .rst_n (rst_int_n), .en (ctrl.ld_x), .d (x_in), .q (x_q)
  );

  quad_dreg #(.W(W)) u_xx_reg (
    .clk (clk), .rst_n (rst_int_n), .en (ctrl.ld_xx), .d (product), .q (xx_q)
  );

  quad_dreg #(.W(W)) u_prod_reg (
    .clk (clk), .rst_n (rst_int_n), .en (ctrl.ld_prod), .d (product), .q (prod_q)
  );

  quad_dreg #(.W(W)) u_bxc_reg (
    .clk (clk), .rst_n (rst_int_n), .en (ctrl.ld_bxc), .d (sum), .q (bxc_q)
  );

  quad_dreg #(.W(W)) u_y_reg (
    .clk (clk), .rst_n (rst_int_n), .en (ctrl.ld_y), .d (sum), .q (y)
  );

endmodule

// File: rtl/quad_eval_chk.sv
module quad_eval_chk
  import quad_pkg::*;
#(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                done,
  input logic signed [W-1:0] y,
  input logic signed [W-1:0] x_q,
  input step_e               step_q
);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_y_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(y));

  assert_done_after_final_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(step_q) == ST_FINAL));

  assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_SQR) |=> (step_q == ST_BX));

  assert_x_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != ST_IDLE) |=> $stable(x_q));

  assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_IDLE && !start) |=> (step_q == ST_IDLE));

endmodule

bind quad_eval quad_eval_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .done   (done),
  .y      (y),
  .x_q    (x_q),
  .step_q (step_q)
);

// File: tb/quad_eval_test.sv
`timescale 1ns/1ps
module quad_eval_test;

  localparam int W = 4;
  localparam int LIM = 200000;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic signed [W-1:0] x_in = '0;
  logic signed [W-1:0] coef_a = '0;
  logic signed [W-1:0] coef_b = '0;
  logic signed [W-1:0] coef_c = '0;
  logic signed [W-1:0] y;
  logic                done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  quad_eval #(.W(W)) uut (
    .clk (clk), .rst_n (rst_n), .start (start), .x_in (x_in),
    .coef_a (coef_a), .coef_b (coef_b), .coef_c (coef_c),
    .y (y), .done (done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input int xv, input int av, input int bv, input int cv);
    int full;
    full = av * xv * xv + bv * xv + cv;
    return full[W-1:0];
  endfunction

  // Called at a negedge; returns at the negedge where done should be high.
  task automatic run_eval(input int xv, input int av, input int bv, input int cv,
                          input bit noise);
    logic [W-1:0] exp_y;
    exp_y  = model(xv, av, bv, cv);
    x_in   = W'(xv);
    coef_a = W'(av);
    coef_b = W'(bv);
    coef_c = W'(cv);
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      chk(done == 1'b0, (k == 1) ? "R6 done low after accept" : "R3 done early",
          int'(done), 0);
      if (noise) begin
        start = 1'b1;
        x_in  = ~x_in;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1, "R3 done after fifth edge", int'(done), 1);
    chk(y == exp_y, noise ? "R4 result with busy noise" : "R2 result",
        int'(y), int'(exp_y));
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > LIM) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIM);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin : main
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(y == '0, "R1 y after reset", int'(y), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);

    // idle with x wiggling, no start
    for (int k = 0; k < 6; k++) begin
      x_in = W'(k);
      @(negedge clk);
      chk(done == 1'b0 && y == '0, "R8 idle no start", int'(y), 0);
    end

    // back-to-back sweep over x, A, B (R7: each start issued while done is high)
    for (int xv = -8; xv < 8; xv++)
      for (int av = -8; av < 8; av++)
        for (int bv = -8; bv < 8; bv++)
          run_eval(xv, av, bv, (3 * xv + av - bv) % 8, 1'b0);

    // y holds and done stays low while idle afterwards
    held = y;
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", int'(done), 0);
    for (int k = 0; k < 5; k++) begin
      x_in = W'(k + 3);
      @(negedge clk);
      chk(y == held, "R5 y holds while idle", int'(y), int'(held));
      chk(done == 1'b0, "R8 no done without start", int'(done), 0);
    end

    // busy-window noise on start and x
    for (int xv = -8; xv < 8; xv++)
      run_eval(xv, 7 - xv, xv - 3, -8, 1'b1);
    held = y;
    @(negedge clk);
    chk(done == 1'b0, "R4 only one done per evaluation", int'(done), 0);
    chk(y == held, "R5 y holds after result", int'(y), int'(held));

    // boundary operands
    run_eval(-8, -8, -8, -8, 1'b0);
    run_eval(7, 7, 7, 7, 1'b0);
    run_eval(0, 7, -8, 5, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule